// File: doc/BRIEF.md
# Instruction Prefix and Length Sequencer

This block sits at the front of a byte-serial instruction decoder. It takes instruction bytes one at a time over a valid/ready handshake. With each byte comes a small classification from an external opcode classifier: whether the byte is a prefix and of which kind, and, for an opcode byte, whether immediate data follows and with which width and sign controls. The block gathers any number of prefix bytes into one set of flags: bus lock, repeat, repeat-while-not-equal, and a segment override with its 2-bit index.

Accumulation ends at the first opcode byte. The block then collects the trailing immediate bytes, which may be one byte (sign- or zero-extended to 16 bits) or two bytes in little-endian order. It then presents one result for the whole instruction: the flags, the immediate value and the total length in bytes.

If the running byte count rises above a parameterised maximum, the block ends the instruction at once and reports it as invalid with every result field cleared. After each result the flags and the count start over from zero for the next instruction.

Top module: `pfx_len_seq`

## Requirements
- R1: `cls_kind` is coded 0 = opcode, 1 = lock prefix, 2 = repeat prefix, 3 = segment prefix. A lock prefix byte sets the lock flag of the result, and the next byte is taken as part of the same instruction.
- R2: A repeat prefix sets the repeat flag. If bit 0 of that prefix byte is 0, it also sets the repeat-not-equal flag. Repeat-not-equal is never reported without repeat.
- R3: A segment prefix sets the segment flag and takes bits [4:3] of the prefix byte as the segment index. When several segment prefixes appear, the last one decides the index.
- R4: The reported length counts all prefix bytes, the opcode byte and the immediate bytes. `res_done` is high in the cycle after the final byte is accepted.
- R5: If accepting a byte makes the count exceed MAX_LEN (default 15), that byte ends the instruction. The result then has `res_invalid`=1, and the length, immediate and all flags are 0. An instruction of exactly MAX_LEN bytes is valid.
- R6: An opcode byte with `cls_has_imm`=0 has no immediate (value 0). With `cls_has_imm`=1, the immediate is two bytes when `cls_w`=1 and `cls_s`=0, and one byte otherwise.
- R7: A one-byte immediate is sign-extended to 16 bits when `cls_s`=1, and zero-extended otherwise.
- R8: A two-byte immediate takes its first byte as bits [7:0] and its second byte as bits [15:8].
- R9: The prefix flags, the segment index and the byte count are back at zero for the instruction that follows any result, whether valid or invalid.
- R10: `res_done` lasts exactly one cycle, and `in_ready` is low in that cycle. Out of reset, `in_ready`=1 and `res_done`=0.
- R11: The classifier inputs are ignored for immediate bytes. A byte taken as immediate data never changes the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Sequencer can accept a byte |
| in_byte | input | 8 | Instruction byte |
| cls_kind | input | 2 | Classifier: 0 opcode, 1 lock, 2 repeat, 3 segment |
| cls_has_imm | input | 1 | Classifier: opcode has immediate data |
| cls_w | input | 1 | Classifier: width bit of the opcode |
| cls_s | input | 1 | Classifier: sign bit of the opcode |
| res_done | output | 1 | One-cycle result strobe |
| res_invalid | output | 1 | Instruction exceeded MAX_LEN |
| res_lock | output | 1 | Lock flag |
| res_rep | output | 1 | Repeat flag |
| res_repne | output | 1 | Repeat-while-not-equal flag |
| res_seg_en | output | 1 | Segment override present |
| res_seg | output | 2 | Segment index |
| res_imm | output | 16 | Immediate value, extended to 16 bits |
| res_len | output | LEN_W (5) | Total instruction length in bytes |

## Verification
The case that needs care is the byte that both completes an instruction and pushes the count past the limit. Both the completion path and the length guard act in that one cycle, and the guard must win. The bench provokes this in two ways. In one, thirteen lock prefixes precede an opcode with a two-byte immediate, so the final immediate byte is the sixteenth. In the other, fifteen prefixes precede a plain opcode. Each is set beside an instruction of exactly fifteen bytes. The scoreboard expects an invalid, all-zero result on the crossing byte and a clean length of 15 at the boundary. It then expects the next instruction to start with no flags carried over.

// File: rtl/pfx_len_pkg.sv
package pfx_len_pkg;

   typedef enum logic [1:0] {
      K_OPC  = 2'd0,
      K_LOCK = 2'd1,
      K_REP  = 2'd2,
      K_SEG  = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      S_PFX    = 2'd0,
      S_IMM_LO = 2'd1,
      S_IMM_HI = 2'd2,
      S_DONE   = 2'd3
   } state_e;

   typedef struct packed {
      logic       lock;
      logic       rep;
      logic       repne;
      logic       seg_en;
      logic [1:0] seg;
   } pfx_t;

endpackage

// File: rtl/pfx_len_acc.sv
module pfx_len_acc
   import pfx_len_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SEG_LSB   = 3,
   parameter int REP_Z_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              clr,
   input  kind_e             kind,
   input  logic [DATA_W-1:0] byte_in,
   output pfx_t              cur
);

   if (SEG_LSB + 2 > DATA_W) begin : g_bad_seg
      $error("segment field does not fit in the byte");
   end
   if (REP_Z_BIT >= DATA_W) begin : g_bad_z
      $error("repeat z bit outside the byte");
   end

   pfx_t nxt;

   always_comb begin
      nxt = cur;
      if (take) begin
         case (kind)
            K_LOCK: nxt.lock = 1'b1;
            K_REP: begin
               nxt.rep = 1'b1;
               if (!byte_in[REP_Z_BIT]) nxt.repne = 1'b1;
            end
            K_SEG: begin
               nxt.seg_en = 1'b1;
               nxt.seg    = byte_in[SEG_LSB +: 2];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cur <= '0;
      else if (clr) cur <= '0;
      else          cur <= nxt;
   end

   AST_REPNE_NEEDS_REP: assert property (@(posedge clk) disable iff (!rst_n)
      cur.repne |-> cur.rep); // R2

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cur == '0); // R9

endmodule

// File: rtl/pfx_len_guard.sv
module pfx_len_guard #(
   parameter int MAX_LEN = 15,
   parameter int LEN_W   = $clog2(MAX_LEN + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [LEN_W-1:0] cnt_nxt,
   output logic             over
);

   if (MAX_LEN < 2) begin : g_bad_max
      $error("MAX_LEN must be at least 2");
   end
   if ((1 << LEN_W) <= MAX_LEN + 1) begin : g_bad_w
      $error("LEN_W too narrow for MAX_LEN + 1");
   end

   logic [LEN_W-1:0] cnt;

   assign cnt_nxt = cnt + LEN_W'(1);
   assign over    = cnt_nxt > LEN_W'(MAX_LEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt_nxt;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LEN_W'(MAX_LEN)); // R5

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(cnt)); // R4

endmodule

// File: rtl/pfx_len_imm.sv
module pfx_len_imm #(
   parameter int DATA_W      = 8,
   parameter bit SIGN_EXT_EN = 1'b1,
   localparam int IMM_W      = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_we,
   input  logic              sx,
   input  logic [DATA_W-1:0] byte_in,
   output logic [IMM_W-1:0]  imm_narrow,
   output logic [IMM_W-1:0]  imm_wide
);

   logic [DATA_W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lo_q <= '0;
      else if (lo_we) lo_q <= byte_in;
   end

   assign imm_wide = {byte_in, lo_q};

   if (SIGN_EXT_EN) begin : g_sext
      assign imm_narrow = sx ? {{DATA_W{byte_in[DATA_W-1]}}, byte_in}
                             : {{DATA_W{1'b0}}, byte_in};
   end else begin : g_zext
      logic unused_sx;
      assign unused_sx  = sx;
      assign imm_narrow = {{DATA_W{1'b0}}, byte_in};
   end

endmodule

// File: rtl/pfx_len_seq.sv
module pfx_len_seq
   import pfx_len_pkg::*;
#(
   parameter int  MAX_LEN = 15,
   localparam int LEN_W   = $clog2(MAX_LEN + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [7:0]       in_byte,
   input  logic [1:0]       cls_kind,
   input  logic             cls_has_imm,
   input  logic             cls_w,
   input  logic             cls_s,
   output logic             res_done,
   output logic             res_invalid,
   output logic             res_lock,
   output logic             res_rep,
   output logic             res_repne,
   output logic             res_seg_en,
   output logic [1:0]       res_seg,
   output logic [15:0]      res_imm,
   output logic [LEN_W-1:0] res_len
);

   localparam int DATA_W = 8;

   state_e           state, state_nxt;
   logic             hs, finish, pfx_take, lo_we, arm_imm;
   logic             wide_q, sx_q;
   logic [LEN_W-1:0] cnt_nxt;
   logic             over;
   pfx_t             pfx_cur;
   logic [15:0]      imm_narrow, imm_wide, imm_sel;
   kind_e            kind;

   assign kind     = kind_e'(cls_kind);
   assign in_ready = (state != S_DONE);
   assign hs       = in_valid && in_ready;
   assign res_done = (state == S_DONE);

   always_comb begin
      state_nxt = state;
      finish    = 1'b0;
      pfx_take  = 1'b0;
      lo_we     = 1'b0;
      arm_imm   = 1'b0;
      imm_sel   = '0;
      case (state)
         S_PFX: if (hs) begin
            if (over)                finish = 1'b1;
            else if (kind != K_OPC)  pfx_take = 1'b1;
            else if (cls_has_imm) begin
               arm_imm   = 1'b1;
               state_nxt = S_IMM_LO;
            end else                 finish = 1'b1;
         end
         S_IMM_LO: if (hs) begin
            if (over) finish = 1'b1;
            else if (wide_q) begin
               lo_we     = 1'b1;
               state_nxt = S_IMM_HI;
            end else begin
               finish  = 1'b1;
               imm_sel = imm_narrow;
            end
         end
         S_IMM_HI: if (hs) begin
            finish  = 1'b1;
            imm_sel = imm_wide;
         end
         default: state_nxt = S_PFX;
      endcase
      if (finish) state_nxt = S_DONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_PFX;
         wide_q <= 1'b0;
         sx_q   <= 1'b0;
      end else begin
         state <= state_nxt;
         if (arm_imm) begin
            wide_q <= cls_w && !cls_s;
            sx_q   <= cls_s;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_invalid <= 1'b0;
         res_lock    <= 1'b0;
         res_rep     <= 1'b0;
         res_repne   <= 1'b0;
         res_seg_en  <= 1'b0;
         res_seg     <= '0;
         res_imm     <= '0;
         res_len     <= '0;
      end else if (finish) begin
         res_invalid <= over;
         res_lock    <= !over && pfx_cur.lock;
         res_rep     <= !over && pfx_cur.rep;
         res_repne   <= !over && pfx_cur.repne;
         res_seg_en  <= !over && pfx_cur.seg_en;
         res_seg     <= over ? 2'b00 : pfx_cur.seg;
         res_imm     <= over ? 16'h0000 : imm_sel;
         res_len     <= over ? '0 : cnt_nxt;
      end
   end

   pfx_len_acc #(.DATA_W(DATA_W), .SEG_LSB(3), .REP_Z_BIT(0)) u_acc (
      .clk(clk), .rst_n(rst_n), .take(pfx_take), .clr(finish),
      .kind(kind), .byte_in(in_byte), .cur(pfx_cur)
   );

   pfx_len_guard #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_guard (
      .clk(clk), .rst_n(rst_n), .inc(hs), .clr(finish),
      .cnt_nxt(cnt_nxt), .over(over)
   );

   pfx_len_imm #(.DATA_W(DATA_W), .SIGN_EXT_EN(1'b1)) u_imm (
      .clk(clk), .rst_n(rst_n), .lo_we(lo_we), .sx(sx_q),
      .byte_in(in_byte), .imm_narrow(imm_narrow), .imm_wide(imm_wide)
   );

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |=> !res_done); // R10

   AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && res_invalid) |-> (res_len == '0 && res_imm == 16'h0 &&
         !res_lock && !res_rep && !res_repne && !res_seg_en && res_seg == 2'b00)); // R5

   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && !res_invalid) |-> (res_len >= LEN_W'(1) && res_len <= LEN_W'(MAX_LEN))); // R4

   AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IMM_HI) |-> ($past(state) == S_IMM_LO || $past(state) == S_IMM_HI)); // R8

   AST_REP_PAIR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |-> (!res_repne || res_rep)); // R2

endmodule

// File: tb/pfx_len_seq_tb.sv
module pfx_len_seq_tb;

   localparam int MAX_LEN = 15;
   localparam int LEN_W   = $clog2(MAX_LEN + 2);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [7:0] in_byte = '0;
   logic [1:0] cls_kind = '0;
   logic cls_has_imm = 1'b0, cls_w = 1'b0, cls_s = 1'b0;
   logic res_done, res_invalid, res_lock, res_rep, res_repne, res_seg_en;
   logic [1:0] res_seg;
   logic [15:0] res_imm;
   logic [LEN_W-1:0] res_len;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   typedef struct {
      string       tag;
      logic [22:0] fields; // inv lock rep repne segen seg[2] imm[16]
      int          len;
   } exp_t;

   exp_t exp_q[$];

   always #5 clk = ~clk;

   pfx_len_seq #(.MAX_LEN(MAX_LEN)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_byte(in_byte), .cls_kind(cls_kind), .cls_has_imm(cls_has_imm),
      .cls_w(cls_w), .cls_s(cls_s), .res_done(res_done),
      .res_invalid(res_invalid), .res_lock(res_lock), .res_rep(res_rep),
      .res_repne(res_repne), .res_seg_en(res_seg_en), .res_seg(res_seg),
      .res_imm(res_imm), .res_len(res_len)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] want);
      checks++;
      if (got !== want) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, got, want);
      end
   endtask

   task automatic expect_res(input string tag, input bit inv, input bit lk, input bit rp,
                             input bit rne, input bit sen, input logic [1:0] sg,
                             input logic [15:0] im, input int ln);
      exp_t e;
      e.tag    = tag;
      e.fields = {inv, lk, rp, rne, sen, sg, im};
      e.len    = ln;
      exp_q.push_back(e);
   endtask

   // driver: called at a negedge, returns at the negedge after acceptance
   task automatic send(input logic [7:0] b, input logic [1:0] k,
                       input bit hi = 0, input bit w = 0, input bit s = 0);
      in_valid = 1'b1; in_byte = b; cls_kind = k;
      cls_has_imm = hi; cls_w = w; cls_s = s;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0; cls_kind = 2'd0; cls_has_imm = 0; cls_w = 0; cls_s = 0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && res_done) begin
         check("R10 ready low during done", 64'(in_ready), 64'd0);
         if (exp_q.size() == 0) begin
            check("R4 unexpected result", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, 64'({res_invalid, res_lock, res_rep, res_repne, res_seg_en,
                              res_seg, res_imm}), 64'(e.fields));
            check({e.tag, " len"}, 64'(res_len), 64'(e.len));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset ready", 64'(in_ready), 64'd1);
      check("R10 reset done", 64'(res_done), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 lock prefix then opcode
      expect_res("R1 lock", 0, 1, 0, 0, 0, 2'd0, 16'h0, 2);
      send(8'hF0, 2'd1); send(8'h90, 2'd0);
      // R9 flags cleared for the next instruction; plain opcode
      expect_res("R9 clean after lock", 0, 0, 0, 0, 0, 2'd0, 16'h0, 1);
      send(8'h90, 2'd0);
      // R2 repeat with bit0=1: no not-equal
      expect_res("R2 rep", 0, 0, 1, 0, 0, 2'd0, 16'h0, 2);
      send(8'hF3, 2'd2); @(negedge clk); send(8'hA4, 2'd0);
      // R2 repeat with bit0=0: not-equal
      expect_res("R2 repne", 0, 0, 1, 1, 0, 2'd0, 16'h0, 2);
      send(8'hF2, 2'd2); send(8'hA6, 2'd0);
      // R3 segment index from bits [4:3]
      expect_res("R3 seg 1", 0, 0, 0, 0, 1, 2'd1, 16'h0, 2);
      send(8'h2E, 2'd3); send(8'h8B, 2'd0);
      // R3 last segment prefix wins
      expect_res("R3 seg last wins", 0, 0, 0, 0, 1, 2'd3, 16'h0, 3);
      send(8'h26, 2'd3); send(8'h3E, 2'd3); send(8'h90, 2'd0);
      // R7 one byte, sign-extended
      expect_res("R7 sext", 0, 0, 0, 0, 0, 2'd0, 16'hFFF0, 2);
      send(8'h83, 2'd0, 1, 1, 1); send(8'hF0, 2'd0);
      // R7 one byte, zero-extended
      expect_res("R7 zext", 0, 0, 0, 0, 0, 2'd0, 16'h00F0, 2);
      send(8'hB0, 2'd0, 1, 0, 0); @(negedge clk); send(8'hF0, 2'd0);
      // R8 R6 two bytes little-endian
      expect_res("R8 wide", 0, 0, 0, 0, 0, 2'd0, 16'h1234, 3);
      send(8'hB8, 2'd0, 1, 1, 0); send(8'h34, 2'd0); send(8'h12, 2'd0);
      // R6 w=1 s=1 gives one byte
      expect_res("R6 w with s narrow", 0, 0, 0, 0, 0, 2'd0, 16'h007F, 2);
      send(8'h83, 2'd0, 1, 1, 1); send(8'h7F, 2'd0);
      // R11 classifier ignored on immediate bytes
      expect_res("R11 imm ignores cls", 0, 0, 0, 0, 0, 2'd0, 16'h00F0, 2);
      send(8'hB0, 2'd0, 1, 0, 0); send(8'hF0, 2'd1, 1, 1, 0);
      // R4 mixed prefixes and immediate
      expect_res("R4 mixed", 0, 1, 1, 1, 1, 2'd0, 16'h0055, 5);
      send(8'hF2, 2'd2); send(8'h26, 2'd3); send(8'hF0, 2'd1);
      send(8'hB0, 2'd0, 1, 0, 0); send(8'h55, 2'd0);
      // R5 exactly MAX_LEN is valid
      expect_res("R5 exact max", 0, 1, 0, 0, 0, 2'd0, 16'h0, MAX_LEN);
      for (int i = 0; i < MAX_LEN - 1; i++) send(8'hF0, 2'd1);
      send(8'h90, 2'd0);
      // R5 opcode is the crossing byte
      expect_res("R5 over on opcode", 1, 0, 0, 0, 0, 2'd0, 16'h0, 0);
      for (int i = 0; i < MAX_LEN; i++) send(8'hF0, 2'd1);
      send(8'h90, 2'd0);
      // R5 last immediate byte both completes and crosses
      expect_res("R5 over on imm hi", 1, 0, 0, 0, 0, 2'd0, 16'h0, 0);
      for (int i = 0; i < MAX_LEN - 2; i++) send(8'hF0, 2'd1);
      send(8'hB8, 2'd0, 1, 1, 0); send(8'h34, 2'd0); send(8'h12, 2'd0);
      // R5 crossing on a prefix byte
      expect_res("R5 over on prefix", 1, 0, 0, 0, 0, 2'd0, 16'h0, 0);
      for (int i = 0; i < MAX_LEN + 1; i++) send(8'h2E, 2'd3);
      // R9 fresh start after invalid
      expect_res("R9 clean after invalid", 0, 0, 0, 0, 0, 2'd0, 16'h0, 1);
      send(8'h90, 2'd0);

      repeat (5) @(negedge clk);
      check("R4 all results seen", 64'(exp_q.size()), 64'd0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule